// File: doc/BRIEF.md
# Windowed Sample-and-Repeat Capture Controller

This block runs a two-phase capture engine around an external linear sample memory. In sample mode it stores one 32-bit input word per clock at consecutive memory addresses, beginning at address 0, and stops writing once every location holds a sample. In repeat mode it stops writing. It reads back only the span that two cursor inputs enclose, and it plays that span out again and again with no idle cycle between passes.

Each pass raises a one-clock trigger pulse together with the first word of the span. An analog oscilloscope that is triggered by this pulse can then show a short slice of the capture as a bright, steady trace. The cursors may be given in either order, and a new cursor setting takes effect only once the current pass has finished. A change of mode abandons whatever pass or capture is in progress.

The memory is assumed to return read data one clock after it is given an address. The replay outputs are registered so that they line up with that returned word.

Top module: `capwin_ctrl`

## Requirements
- R1: In sample mode (`rep_mode` = 0) `mem_we` is high and `mem_wdata` equals `smp_data` in each clock, and `mem_addr` steps by one per clock, starting at 0.
- R2: After DEPTH words have been written (addresses 0 to DEPTH-1), `mem_we` stays low until sample mode is entered again.
- R3: Entering sample mode from repeat mode starts a new capture at address 0 in the clock that follows the mode-change edge.
- R4: In repeat mode (`rep_mode` = 1) the words at addresses lo, lo+1, ..., hi appear on `play_data` with `play_valid` high, one clock after each address is issued. The sequence then restarts at lo with no gap.
- R5: The window is lo = min(`cur_start`, `cur_end`) and hi = max(`cur_start`, `cur_end`), so reversed cursors are swapped. Equal cursors give a one-word window that is replayed every clock.
- R6: A cursor change made during a pass takes effect only after the word at the old hi has been issued. The current pass always completes.
- R7: `play_trig` is high for exactly the one clock in which `play_data` carries the word from address lo, on every pass. It is never high without `play_valid`.
- R8: A change of `rep_mode` aborts the pass in progress. The clock after the mode-change edge shows `play_valid` = 0, and `play_valid` and `play_trig` are 0 in reset and in sample mode.
- R9: `mem_we` is 0 throughout repeat mode and in the clock in which a mode change is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rep_mode | input | 1 | 0 = sample, 1 = repeat |
| smp_data | input | DW | Sample input word |
| cur_start | input | AW | Window cursor A |
| cur_end | input | AW | Window cursor B |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one clock after the address |
| play_data | output | DW | Replayed word (0 when not valid) |
| play_valid | output | 1 | Replay word valid |
| play_trig | output | 1 | Trigger pulse at the head of each pass |

## Verification
Two events can land on the same clock in this block. The first is the wrap from hi back to lo, which is also the only point where new cursors are taken up. The bench changes the cursors in the middle of a pass and again on single-word windows, where a wrap occurs on every clock. The scoreboard then requires the remaining words of the old window, followed by a trigger on the new lo. The second collision is between a mode change and an in-flight read or a pending write. The bench switches modes while a word is still being read and while a capture is filling, then checks that the aborted word never appears and that no write slips through.

// File: rtl/capwin_pkg.sv
package capwin_pkg;
   typedef enum logic {
      CW_SAMPLE = 1'b0,
      CW_REPEAT = 1'b1
   } cw_mode_e;
endpackage

// File: rtl/capwin_sort.sv
module capwin_sort #(
   parameter int AW = 21
) (
   input  logic [AW-1:0] cur_a,
   input  logic [AW-1:0] cur_b,
   output logic [AW-1:0] lo,
   output logic [AW-1:0] hi
);
   // order the two cursors so the window always runs upward
   always_comb begin
      if (cur_b < cur_a) begin
         lo = cur_b;
         hi = cur_a;
      end else begin
         lo = cur_a;
         hi = cur_b;
      end
   end
endmodule

// File: rtl/capwin_writer.sv
module capwin_writer #(
   parameter int DEPTH = 2097152,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          restart,
   output logic          we,
   output logic [AW-1:0] addr
);
   logic full_q;
   logic last;

   generate
      if (DEPTH == (1 << AW)) begin : g_pow2
         assign last = &addr;
      end else begin : g_cmp
         assign last = (addr == AW'(DEPTH - 1));
      end
   endgenerate

   assign we = active && !full_q && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr   <= '0;
         full_q <= 1'b0;
      end else if (restart) begin
         addr   <= '0;
         full_q <= 1'b0;
      end else if (we) begin
         if (last) full_q <= 1'b1;
         else      addr   <= addr + 1'b1;
      end
   end

   AST_FULL_STOPS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      full_q |-> !we); // R2
   AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (!we || addr == $past(addr) + 1'b1)); // R1
endmodule

// File: rtl/capwin_reader.sv
module capwin_reader #(
   parameter int AW = 21
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          restart,
   input  logic [AW-1:0] new_lo,
   input  logic [AW-1:0] new_hi,
   output logic [AW-1:0] addr,
   output logic          head
);
   logic [AW-1:0] win_lo;
   logic [AW-1:0] win_hi;

   assign head = active && (addr == win_lo);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_lo <= '0;
         win_hi <= '0;
         addr   <= '0;
      end else if (restart || (active && addr == win_hi)) begin
         win_lo <= new_lo;
         win_hi <= new_hi;
         addr   <= new_lo;
      end else if (active) begin
         addr <= addr + 1'b1;
      end
   end

   AST_PTR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (addr >= win_lo && addr <= win_hi)); // R5
   AST_WINDOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !restart && addr != win_hi) |=> ($stable(win_lo) && $stable(win_hi))); // R6
endmodule

// File: rtl/capwin_ctrl.sv
module capwin_ctrl
   import capwin_pkg::*;
#(
   parameter int DW    = 32,
   parameter int DEPTH = 2097152,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rep_mode,
   input  logic [DW-1:0] smp_data,
   input  logic [AW-1:0] cur_start,
   input  logic [AW-1:0] cur_end,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] play_data,
   output logic          play_valid,
   output logic          play_trig
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("capwin_ctrl: DEPTH must be at least 2");
      end
      if (DW < 1) begin : g_bad_width
         $error("capwin_ctrl: DW must be at least 1");
      end
   endgenerate

   cw_mode_e      mode_q;
   logic          restart;
   logic          smp_act;
   logic          rep_act;
   logic [AW-1:0] w_addr;
   logic [AW-1:0] r_addr;
   logic [AW-1:0] srt_lo;
   logic [AW-1:0] srt_hi;
   logic          r_head;
   logic          valid_q;
   logic          trig_q;

   assign restart = (cw_mode_e'(rep_mode) != mode_q);
   assign smp_act = (mode_q == CW_SAMPLE);
   assign rep_act = (mode_q == CW_REPEAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= CW_SAMPLE;
      else        mode_q <= cw_mode_e'(rep_mode);
   end

   capwin_sort #(.AW(AW)) u_sort (
      .cur_a (cur_start),
      .cur_b (cur_end),
      .lo    (srt_lo),
      .hi    (srt_hi)
   );

   capwin_writer #(.DEPTH(DEPTH), .AW(AW)) u_writer (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (smp_act),
      .restart (restart),
      .we      (mem_we),
      .addr    (w_addr)
   );

   capwin_reader #(.AW(AW)) u_reader (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (rep_act),
      .restart (restart),
      .new_lo  (srt_lo),
      .new_hi  (srt_hi),
      .addr    (r_addr),
      .head    (r_head)
   );

   assign mem_addr  = smp_act ? w_addr : r_addr;
   assign mem_wdata = smp_data;

   // flags follow the address by one clock, matching the memory read latency
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         trig_q  <= 1'b0;
      end else begin
         valid_q <= rep_act && !restart;
         trig_q  <= r_head && !restart;
      end
   end

   assign play_valid = valid_q;
   assign play_trig  = trig_q;
   assign play_data  = valid_q ? mem_rdata : '0;

   AST_TRIG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      play_trig |-> play_valid); // R7
   AST_NO_WRITE_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_act || restart) |-> !mem_we); // R9
   AST_ABORT_DROPS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !play_valid); // R8
endmodule

// File: tb/capwin_ctrl_tb.sv
module capwin_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int DEPTH = 64;
   localparam int AW = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rep_mode = 1'b0;
   logic [DW-1:0] smp_data = '0;
   logic [AW-1:0] cur_start = '0;
   logic [AW-1:0] cur_end = '0;
   logic [AW-1:0] mem_addr;
   logic          mem_we;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata;
   logic [DW-1:0] play_data;
   logic          play_valid;
   logic          play_trig;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string cur_req = "R4";

   logic [DW-1:0] bmem    [DEPTH];
   logic [DW-1:0] exp_mem [DEPTH];
   logic [DW-1:0] q_data  [$];
   bit            q_trig  [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   capwin_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .rep_mode(rep_mode), .smp_data(smp_data),
      .cur_start(cur_start), .cur_end(cur_end), .mem_addr(mem_addr),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .play_data(play_data), .play_valid(play_valid), .play_trig(play_trig)
   );

   // memory with one clock of read latency
   always @(posedge clk) begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      mem_rdata <= bmem[mem_addr];
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever a replay word appears
   always @(negedge clk) begin
      if (rst_n && play_valid) begin
         if (q_data.size() == 0) begin
            chk(1'b0, "R8", "unexpected play_valid", 1, 0);
         end else begin
            logic [DW-1:0] ed;
            bit            et;
            ed = q_data.pop_front();
            et = q_trig.pop_front();
            chk(play_data == ed, cur_req, "play_data", play_data, ed);
            chk(play_trig == et, (cur_req == "R4") ? "R7" : cur_req, "play_trig",
                DW'(play_trig), DW'(et));
         end
      end
   end

   function automatic logic [DW-1:0] pat(input int seed, input int i);
      return {16'(seed * 16'h3A71), 16'(i)} ^ 32'hC3000000;
   endfunction

   // cycle 0 is the clock in progress at the call
   task automatic sample_run(input int n, input int seed, input string req);
      for (int i = 0; i < n; i++) begin
         smp_data = pat(seed, i);
         #1;
         if (i < DEPTH) begin
            chk(mem_we === 1'b1, req, "mem_we during capture", DW'(mem_we), 1);
            chk(mem_addr == AW'(i), req, "capture address", DW'(mem_addr), DW'(i));
            chk(mem_wdata == smp_data, "R1", "mem_wdata", mem_wdata, smp_data);
            exp_mem[i] = smp_data;
         end else begin
            chk(mem_we === 1'b0, "R2", "mem_we after full", DW'(mem_we), 0);
         end
         @(negedge clk);
      end
   endtask

   task automatic repeat_run(input logic [AW-1:0] ca, input logic [AW-1:0] cb, input int ncyc,
                             input int chg_k, input logic [AW-1:0] na, input logic [AW-1:0] nb,
                             input string req);
      logic [AW-1:0] lo, hi, p;
      cur_req   = req;
      cur_start = ca;
      cur_end   = cb;
      rep_mode  = 1'b1;
      #1;
      chk(mem_we === 1'b0, "R9", "mem_we on mode change", DW'(mem_we), 0);
      lo = (cb < ca) ? cb : ca;
      hi = (cb < ca) ? ca : cb;
      p  = lo;
      @(negedge clk);
      for (int k = 1; k < ncyc; k++) begin
         if (k == chg_k) begin
            cur_start = na;
            cur_end   = nb;
         end
         q_data.push_back(exp_mem[p]);
         q_trig.push_back(p == lo);
         #1;
         chk(mem_we === 1'b0, "R9", "mem_we in repeat", DW'(mem_we), 0);
         if (p == hi) begin
            lo = (cur_end < cur_start) ? cur_end : cur_start;
            hi = (cur_end < cur_start) ? cur_start : cur_end;
            p  = lo;
         end else begin
            p = p + 1'b1;
         end
         @(negedge clk);
      end
      rep_mode = 1'b0;
      @(negedge clk);
      chk(play_valid === 1'b0, "R8", "play_valid after abort", DW'(play_valid), 0);
      chk(q_data.size() == 0, "R8", "scoreboard drained", DW'(q_data.size()), 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(play_valid === 1'b0, "R8", "reset play_valid", DW'(play_valid), 0);
      chk(play_trig === 1'b0, "R7", "reset play_trig", DW'(play_trig), 0);
      chk(mem_addr == '0, "R1", "reset address", DW'(mem_addr), 0);
      rst_n = 1'b1;
      // R1 R2: fill and overrun
      sample_run(DEPTH + 6, 1, "R1");
      // R4 R7: plain window
      repeat_run(AW'(5), AW'(12), 30, 0, '0, '0, "R4");
      // R5: reversed cursors
      repeat_run(AW'(40), AW'(33), 20, 0, '0, '0, "R5");
      // R5: single-word window, trigger every clock
      repeat_run(AW'(20), AW'(20), 8, 0, '0, '0, "R5");
      // R6: cursor change mid pass
      repeat_run(AW'(10), AW'(20), 25, 4, AW'(55), AW'(50), "R6");
      // R6: change on a one-word window
      repeat_run(AW'(7), AW'(7), 10, 3, AW'(60), AW'(62), "R6");
      // R3: partial new capture restarts at 0
      sample_run(20, 2, "R3");
      // R4: full span with wrap at the top address
      repeat_run(AW'(0), AW'(DEPTH - 1), DEPTH + 10, 0, '0, '0, "R4");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule